// File: doc/BRIEF.md
# Overcurrent Fault Manager

This block sits between the analog protection comparators of a three-phase gate driver and the rest of the chip. It takes raw flags and turns them into latched status words, an active-low fault pin and a bridge-disable command. The raw flags are six drain-source overcurrent flags (high and low switch of phases A, B and C), three sense-amplifier overcurrent flags, six gate-drive fault flags, and the undervoltage, charge-pump undervoltage, overtemperature shutdown and overtemperature warning flags.

Overcurrent flags pass through a per-channel deglitch filter. A 2-bit policy field then sets the response: hold the fault until software clears it, retry automatically after a selectable wait, report only, or ignore. In retry mode an optional cycle-by-cycle setting lets the next PWM event end the fault early. The other fault sources are held until the clear pulse, and separate disable bits can mask them. All timing counts system clocks, and the clocks-per-microsecond value is a parameter.

Top module: `ocp_fault_mgr`

## Requirements
- R1: An overcurrent flag is recognised only when it is sampled high on N+1 consecutive rising clock edges, where N = 2*(deg_sel_i+1)*CYC_PER_US. A flag held high for N edges or fewer is discarded, and any low sample restarts the count.
- R2: With ocp_mode_i = 00, a recognised overcurrent stays set in the status words for as long as no clear pulse arrives, and drv_dis_o is high while it is set.
- R3: With ocp_mode_i = 01, a recognised overcurrent bit is high for exactly R clock cycles and then clears by itself. R = CYC_PER_US*RETRY_LONG_US when retry_short_i = 0 and CYC_PER_US*RETRY_SHORT_US when it is 1. drv_dis_o is high for the whole of that time.
- R4: With ocp_mode_i = 10, a recognised overcurrent sets its status bit and pulls fault_n_o low, and drv_dis_o stays low.
- R5: With ocp_mode_i = 11, overcurrent flags set no status bit, fault_n_o stays high and drv_dis_o stays low.
- R6: With ocp_mode_i = 01 and cbc_en_i = 1, a one-cycle pwm_evt_i clears all overcurrent bits and drops drv_dis_o at the next clock edge. With cbc_en_i = 0, pwm_evt_i has no effect.
- R7: stat1_o carries, from bit 10 down to bit 0: summary fault, OR of the drain-source flags, OR of the gate-drive flags, undervoltage, overtemperature shutdown, and the drain-source flags for high A, low A, high B, low B, high C, low C. vds_oc_i uses the same order in its bits 5..0.
- R8: stat2_o carries the sense flags for phases A, B and C in bits 10, 9 and 8, the overtemperature warning in bit 7 and charge-pump undervoltage in bit 6. Bits 5..0 hold the gate-drive flags in the same switch order as vds_oc_i, and sen_oc_i[2:0] is ordered A, B, C.
- R9: The summary bit stat1_o[10] is the OR of all reportable status bits and is always the inverse of fault_n_o.
- R10: The overtemperature warning always shows in stat2_o[7], but it sets the summary bit and pulls fault_n_o low only when otw_rep_i = 1.
- R11: When gdf_dis_i, cpuv_dis_i or sen_dis_i is 1, the gate-drive flags, the charge-pump undervoltage flag or the sense overcurrent flags respectively set no status bit.
- R12: A one-cycle clr_flt_i clears every latched status bit at the next clock edge.
- R13: After reset both status words are zero, fault_n_o is high and drv_dis_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vds_oc_i | input | 6 | Raw drain-source overcurrent flags, bit 5 = high A ... bit 0 = low C |
| sen_oc_i | input | 3 | Raw sense-amplifier overcurrent flags, bit 2 = A, bit 0 = C |
| vgs_flt_i | input | 6 | Raw gate-drive fault flags, same order as vds_oc_i |
| uvlo_i | input | 1 | Supply undervoltage flag |
| cpuv_i | input | 1 | Charge-pump undervoltage flag |
| otsd_i | input | 1 | Overtemperature shutdown flag |
| otw_i | input | 1 | Overtemperature warning flag |
| pwm_evt_i | input | 1 | One-cycle pulse on a new PWM input |
| clr_flt_i | input | 1 | One-cycle clear-fault pulse |
| ocp_mode_i | input | 2 | Overcurrent policy: 00 latch, 01 retry, 10 report, 11 ignore |
| retry_short_i | input | 1 | Retry time select: 0 long, 1 short |
| deg_sel_i | input | 2 | Deglitch time code, 2/4/6/8 us |
| cbc_en_i | input | 1 | Clear a retried fault on the next PWM event |
| otw_rep_i | input | 1 | Let the warning drive the fault pin |
| gdf_dis_i | input | 1 | Mask gate-drive faults |
| cpuv_dis_i | input | 1 | Mask charge-pump undervoltage |
| sen_dis_i | input | 1 | Mask sense overcurrent flags |
| stat1_o | output | 11 | Status word 1 |
| stat2_o | output | 11 | Status word 2 |
| fault_n_o | output | 1 | Active-low fault pin |
| drv_dis_o | output | 1 | Bridge disable command |

## Verification
A deglitch counter that is off by one shows at the ports as a pulse of exactly N or N+1 edges being handled wrongly. The sweep over all four deglitch codes and all nine channels detects this on the first affected pulse. A retry timer that is off by one, or that is started or stopped on the wrong condition, moves the falling edge of the status bit and of drv_dis_o by one cycle. The bench samples the cycle before and the cycle after that point. A wrong latch or a wrong mode gate shows up as a status bit, a fault pin or a disable level that differs from the requirement at the negedge right after the first affected clock edge.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  typedef enum logic [1:0] {
    OCM_LATCH  = 2'b00,
    OCM_RETRY  = 2'b01,
    OCM_REPORT = 2'b10,
    OCM_IGNORE = 2'b11
  } oc_mode_e;

  localparam int unsigned NUM_VDS = 6;
  localparam int unsigned NUM_SEN = 3;
  localparam int unsigned NUM_OC  = NUM_VDS + NUM_SEN;
  localparam int unsigned STAT_W  = 11;

  // deglitch window in clocks: 2, 4, 6 or 8 microseconds
  function automatic int unsigned deg_cycles(input logic [1:0] code,
                                             input int unsigned cyc_per_us);
    return (32'(code) + 32'd1) * 32'd2 * cyc_per_us;
  endfunction

  // retry wait in clocks
  function automatic int unsigned retry_cycles(input logic short_sel,
                                               input int unsigned cyc_per_us,
                                               input int unsigned long_us,
                                               input int unsigned short_us);
    return (short_sel ? short_us : long_us) * cyc_per_us;
  endfunction

endpackage

// File: rtl/ocp_deglitch.sv
module ocp_deglitch #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          raw,
  input  logic [CW-1:0] thr,
  output logic          qual
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (!raw)      cnt <= '0;
    else if (cnt < thr) cnt <= cnt + 1'b1;
  end

  assign qual = raw && (cnt >= thr);

  AST_QUAL_NEEDS_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && thr != '0) |-> $past(raw)); // R1

endmodule

// File: rtl/ocp_retry_timer.sv
module ocp_retry_timer #(
  parameter int unsigned RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          start,
  input  logic          abort,
  input  logic [RW-1:0] limit,
  output logic          busy,
  output logic          done
);

  logic [RW-1:0] cnt;

  assign done = busy && (cnt == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!en) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (abort || done) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_RETRY_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < limit)); // R3
  AST_RETRY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && en && !abort && !done) |=> busy); // R3

endmodule

// File: rtl/ocp_stat_latch.sv
module ocp_stat_latch #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         clr,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else          q <= q | set;
  end

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0)); // R12
  AST_BITS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((q & $past(q)) == $past(q))); // R2

endmodule

// File: rtl/ocp_fault_mgr.sv
module ocp_fault_mgr
  import ocp_pkg::*;
#(
  parameter int unsigned CYC_PER_US     = 100,
  parameter int unsigned RETRY_LONG_US  = 4000,
  parameter int unsigned RETRY_SHORT_US = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  vds_oc_i,
  input  logic [2:0]  sen_oc_i,
  input  logic [5:0]  vgs_flt_i,
  input  logic        uvlo_i,
  input  logic        cpuv_i,
  input  logic        otsd_i,
  input  logic        otw_i,
  input  logic        pwm_evt_i,
  input  logic        clr_flt_i,
  input  logic [1:0]  ocp_mode_i,
  input  logic        retry_short_i,
  input  logic [1:0]  deg_sel_i,
  input  logic        cbc_en_i,
  input  logic        otw_rep_i,
  input  logic        gdf_dis_i,
  input  logic        cpuv_dis_i,
  input  logic        sen_dis_i,
  output logic [10:0] stat1_o,
  output logic [10:0] stat2_o,
  output logic        fault_n_o,
  output logic        drv_dis_o
);

  localparam int unsigned DEG_MAX = 8 * CYC_PER_US;
  localparam int unsigned DW      = $clog2(DEG_MAX + 1);
  localparam int unsigned RMAX    = ((RETRY_LONG_US > RETRY_SHORT_US) ?
                                     RETRY_LONG_US : RETRY_SHORT_US) * CYC_PER_US;
  localparam int unsigned RW      = $clog2(RMAX + 1);

  oc_mode_e mode;
  logic m_latch, m_retry, m_report, m_ignore;
  assign mode     = oc_mode_e'(ocp_mode_i);
  assign m_latch  = (mode == OCM_LATCH);
  assign m_retry  = (mode == OCM_RETRY);
  assign m_report = (mode == OCM_REPORT);
  assign m_ignore = (mode == OCM_IGNORE);

  logic [DW-1:0] deg_thr;
  logic [RW-1:0] retry_lim;
  assign deg_thr   = DW'(deg_cycles(deg_sel_i, CYC_PER_US));
  assign retry_lim = RW'(retry_cycles(retry_short_i, CYC_PER_US,
                                      RETRY_LONG_US, RETRY_SHORT_US));

  // overcurrent channels: [5:0] drain-source, [8:6] sense A,B,C
  logic [NUM_OC-1:0] oc_raw, oc_qual, oc_set, oc_lat;
  assign oc_raw = {sen_oc_i & {NUM_SEN{~sen_dis_i}}, vds_oc_i};

  for (genvar g = 0; g < NUM_OC; g++) begin : g_dg
    ocp_deglitch #(.CW(DW)) u_dg (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (oc_raw[g]),
      .thr  (deg_thr),
      .qual (oc_qual[g])
    );
  end

  // named internal events
  logic rt_busy, rt_done, pwm_clear, oc_clr, rt_start, oc_gate;
  assign pwm_clear = m_retry && cbc_en_i && pwm_evt_i;
  assign oc_clr    = clr_flt_i || m_ignore || (m_retry && (rt_done || pwm_clear));
  assign oc_gate   = !m_ignore && !(m_retry && rt_busy);
  assign oc_set    = oc_qual & {NUM_OC{oc_gate}};
  assign rt_start  = m_retry && (|oc_set) && !oc_clr;

  ocp_retry_timer #(.RW(RW)) u_rt (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (m_retry),
    .start(rt_start),
    .abort(clr_flt_i || pwm_clear),
    .limit(retry_lim),
    .busy (rt_busy),
    .done (rt_done)
  );

  ocp_stat_latch #(.W(NUM_OC)) u_oc_lat (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (oc_set),
    .clr  (oc_clr),
    .q    (oc_lat)
  );

  logic [5:0] vgs_lat;
  ocp_stat_latch #(.W(6)) u_vgs_lat (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (vgs_flt_i & {6{~gdf_dis_i}}),
    .clr  (clr_flt_i),
    .q    (vgs_lat)
  );

  // misc: [3] undervoltage, [2] shutdown, [1] charge pump, [0] warning
  logic [3:0] misc_lat;
  ocp_stat_latch #(.W(4)) u_misc_lat (
    .clk  (clk),
    .rst_n(rst_n),
    .set  ({uvlo_i, otsd_i, cpuv_i & ~cpuv_dis_i, otw_i}),
    .clr  (clr_flt_i),
    .q    (misc_lat)
  );

  logic fault_any;
  assign fault_any = (|oc_lat) || (|vgs_lat) || (|misc_lat[3:1])
                     || (misc_lat[0] && otw_rep_i);

  assign stat1_o   = {fault_any, |oc_lat[5:0], |vgs_lat, misc_lat[3], misc_lat[2],
                      oc_lat[5:0]};
  assign stat2_o   = {oc_lat[8:6], misc_lat[0], misc_lat[1], vgs_lat};
  assign fault_n_o = ~fault_any;
  assign drv_dis_o = (m_latch || m_retry) && ((|oc_lat) || rt_busy);

  AST_REPORT_NO_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    m_report |-> !drv_dis_o); // R4
  AST_IGNORE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    m_ignore |=> (oc_lat == '0)); // R5
  AST_OC_PULLS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (|oc_lat) |-> !fault_n_o); // R9
  AST_CBC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_clear |=> (oc_lat == '0)); // R6
  AST_WARN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!otw_rep_i && oc_lat == '0 && vgs_lat == '0 && misc_lat[3:1] == '0)
      |-> fault_n_o); // R10

endmodule

// File: tb/sim_ocp_fault_mgr.sv
module sim_ocp_fault_mgr;

  localparam int unsigned CYC = 2;
  localparam int unsigned LUS = 4000;
  localparam int unsigned SUS = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] vds = '0, vgs = '0;
  logic [2:0] sen = '0;
  logic uvlo = 0, cpuv = 0, otsd = 0, otw = 0, pwm = 0, clr = 0;
  logic [1:0] mode = 2'b00, deg = 2'b00;
  logic rshort = 0, cbc = 0, otwrep = 0, gdis = 0, cdis = 0, sdis = 0;
  logic [10:0] st1, st2;
  logic fn, dd;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ocp_fault_mgr #(.CYC_PER_US(CYC), .RETRY_LONG_US(LUS), .RETRY_SHORT_US(SUS)) u0 (
    .clk(clk), .rst_n(rst_n), .vds_oc_i(vds), .sen_oc_i(sen), .vgs_flt_i(vgs),
    .uvlo_i(uvlo), .cpuv_i(cpuv), .otsd_i(otsd), .otw_i(otw), .pwm_evt_i(pwm),
    .clr_flt_i(clr), .ocp_mode_i(mode), .retry_short_i(rshort), .deg_sel_i(deg),
    .cbc_en_i(cbc), .otw_rep_i(otwrep), .gdf_dis_i(gdis), .cpuv_dis_i(cdis),
    .sen_dis_i(sdis), .stat1_o(st1), .stat2_o(st2), .fault_n_o(fn), .drv_dis_o(dd)
  );

  function automatic int nq(input int d);
    return 2 * (d + 1) * CYC;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R9: summary bit and pin always agree
  task automatic chk_pin(input string req);
    chk({req, " R9"}, {31'd0, fn}, {31'd0, ~st1[10]});
  endtask

  task automatic clear_pulse();
    @(negedge clk) clr = 1;
    @(negedge clk) clr = 0;
  endtask

  task automatic pulse_vds(input int ch, input int edges);
    @(negedge clk) vds[ch] = 1'b1;
    repeat (edges) @(posedge clk);
    @(negedge clk) vds[ch] = 1'b0;
  endtask

  task automatic pulse_sen(input int ch, input int edges);
    @(negedge clk) sen[ch] = 1'b1;
    repeat (edges) @(posedge clk);
    @(negedge clk) sen[ch] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    chk("R13 stat1", st1, 0);
    chk("R13 stat2", st2, 0);
    chk("R13 fault_n", fn, 1);
    chk("R13 drv_dis", dd, 0);

    // R1 / R7 / R2 / R12 sweep over deglitch codes and drain-source channels
    for (int d = 0; d < 4; d++) begin
      deg = 2'(d);
      for (int ch = 0; ch < 6; ch++) begin
        pulse_vds(ch, nq(d));
        chk("R1 short pulse rejected", st1, 0);
        pulse_vds(ch, nq(d) + 1);
        chk("R7 stat1 layout", st1, (1 << 10) | (1 << 9) | (1 << ch));
        chk("R2 drv_dis latched", dd, 1);
        chk_pin("R9");
        clear_pulse();
        chk("R12 clear", st1, 0);
      end
    end

    // R1 restart: two sub-window bursts separated by one low sample
    deg = 2'd0;
    @(negedge clk) vds[0] = 1;
    repeat (nq(0) - 1) @(posedge clk);
    @(negedge clk) vds[0] = 0;
    @(negedge clk) vds[0] = 1;
    repeat (nq(0) - 1) @(posedge clk);
    @(negedge clk) vds[0] = 0;
    chk("R1 restart on drop", st1, 0);

    // R8 / R11 sense channels
    for (int ch = 0; ch < 3; ch++) begin
      pulse_sen(ch, nq(0) + 1);
      chk("R8 stat2 sense bit", st2, 1 << (8 + ch));
      chk("R9 summary from sense", st1, 1 << 10);
      clear_pulse();
      sdis = 1;
      pulse_sen(ch, nq(0) + 4);
      chk("R11 sense masked", st2, 0);
      sdis = 0;
    end

    // R2 latched hold
    pulse_vds(5, nq(0) + 1);
    repeat (300) @(posedge clk);
    @(negedge clk);
    chk("R2 held after wait", st1[5], 1);
    chk("R2 drv_dis held", dd, 1);
    clear_pulse();
    chk("R12 drv_dis drops", dd, 0);

    // R3 retry, both retry times
    mode = 2'b01;
    for (int s = 0; s < 2; s++) begin
      int r;
      rshort = s[0];
      r = (s == 1) ? SUS * CYC : LUS * CYC;
      pulse_vds(2, nq(0) + 1);
      chk("R3 set in retry", st1[2], 1);
      chk("R3 drv_dis set", dd, 1);
      repeat (r - 1) @(posedge clk);
      @(negedge clk);
      chk("R3 still set at R-1", st1[2], 1);
      chk("R3 drv_dis at R-1", dd, 1);
      @(negedge clk);
      chk("R3 cleared at R", st1[2], 0);
      chk("R3 drv_dis released", dd, 0);
    end

    // R6 cycle-by-cycle clear
    rshort = 0;
    cbc = 0;
    pulse_vds(1, nq(0) + 1);
    repeat (10) @(negedge clk);
    pwm = 1;
    @(negedge clk) pwm = 0;
    chk("R6 pwm ignored without cbc", st1[1], 1);
    clear_pulse();
    chk("R12 clear in retry", st1, 0);
    cbc = 1;
    pulse_sen(0, nq(0) + 1);
    chk("R6 sense set", st2[8], 1);
    repeat (10) @(negedge clk);
    pwm = 1;
    @(negedge clk) pwm = 0;
    chk("R6 pwm clears", st2, 0);
    chk("R6 drv_dis off", dd, 0);
    cbc = 0;

    // R4 report only
    mode = 2'b10;
    pulse_vds(4, nq(0) + 1);
    chk("R4 status set", st1, (1 << 10) | (1 << 9) | (1 << 4));
    chk("R4 pin low", fn, 0);
    chk("R4 no disable", dd, 0);
    clear_pulse();

    // R5 ignore
    mode = 2'b11;
    pulse_vds(3, nq(0) + 6);
    chk("R5 no status", st1, 0);
    chk("R5 pin high", fn, 1);
    chk("R5 no disable", dd, 0);
    mode = 2'b00;

    // R8 / R7 / R11 gate-drive flags
    for (int ch = 0; ch < 6; ch++) begin
      @(negedge clk) vgs = 6'(1 << ch);
      @(negedge clk) vgs = 0;
      chk("R8 stat2 gate bit", st2, 1 << ch);
      chk("R7 stat1 gate summary", st1, (1 << 10) | (1 << 8));
      chk_pin("R9");
      clear_pulse();
      gdis = 1;
      @(negedge clk) vgs = 6'(1 << ch);
      @(negedge clk) vgs = 0;
      chk("R11 gate masked", st2, 0);
      gdis = 0;
    end

    // R7 undervoltage / shutdown positions
    @(negedge clk) uvlo = 1;
    @(negedge clk) uvlo = 0;
    chk("R7 undervoltage bit", st1, (1 << 10) | (1 << 7));
    clear_pulse();
    @(negedge clk) otsd = 1;
    @(negedge clk) otsd = 0;
    chk("R7 shutdown bit", st1, (1 << 10) | (1 << 6));
    clear_pulse();

    // R8 / R11 charge pump
    @(negedge clk) cpuv = 1;
    @(negedge clk) cpuv = 0;
    chk("R8 charge pump bit", st2, 1 << 6);
    chk("R9 summary from pump", st1, 1 << 10);
    clear_pulse();
    cdis = 1;
    @(negedge clk) cpuv = 1;
    @(negedge clk) cpuv = 0;
    chk("R11 pump masked", st2, 0);
    cdis = 0;

    // R10 warning reporting
    otwrep = 0;
    @(negedge clk) otw = 1;
    @(negedge clk) otw = 0;
    chk("R10 warn status", st2, 1 << 7);
    chk("R10 warn no summary", st1, 0);
    chk("R10 warn pin high", fn, 1);
    otwrep = 1;
    @(negedge clk);
    chk("R10 warn summary", st1, 1 << 10);
    chk("R10 warn pin low", fn, 0);
    clear_pulse();
    chk("R12 warn cleared", st2, 0);
    otwrep = 0;

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule